// File: doc/BRIEF.md
# Tagged Load-Balancing Dispatcher with In-Order Reassembly

This block fans a single stream of work items out over a set of parallel processing engines and gathers the finished results back into one stream in the order the items arrived. Each accepted item receives a sequence tag. It is passed straight through to the engine that has the fewest unfinished items.

Engines may finish in any order. Each engine returns the tag alongside its result, and the result is parked in a slot chosen by that tag. The output stream always presents the slot holding the oldest unreleased tag. It waits whenever that slot is still empty, so downstream logic sees the results exactly as a strictly in-order unit would deliver them.

The number of unreleased items is capped at the reorder depth. Because of this cap, a tag value is never handed out again while its slot is still occupied. A result that arrives for a slot that is already occupied is reported as an error.

Top module: `seq_dispatch_reorder`

## Requirements
- R1: After reset, `out_valid` and `dup_err` are low, every engine load is zero, and the first accepted item carries tag 0.
- R2: The Nth accepted item, counting from 0 after reset, is presented on the selected engine's `eng_req_tag` with the value N modulo DEPTH. DEPTH must be a power of two.
- R3: An engine's load is the number of items it has accepted minus the number of results it has returned, and never goes below zero. An item goes to the engine whose load is smallest. When several engines share the smallest load, the lowest index wins.
- R4: When `in_valid` is high and the block has room, only the selected engine's `eng_req_valid` bit is high. `in_ready` equals room AND that engine's `eng_req_ready`. `eng_req_data` of the selected engine carries `in_data` in the same cycle.
- R5: The block has room only while the count of items that have been accepted but not yet released on the output is below DEPTH. At DEPTH, `in_ready` and all `eng_req_valid` bits are low.
- R6: Results are released in acceptance order. The Kth release carries the data returned for the Kth accepted item, and `out_tag` equals K modulo DEPTH.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_tag` hold their values into the next cycle.
- R8: `dup_err` goes high in the same cycle as either of two events: a returning result whose tag slot already holds an unreleased result, or two engines returning the same tag together. In the first case the stored result is kept unchanged. In the second case the lower-index engine's result is the one stored.
- R9: `eng_rsp_ready` is high for every engine in every cycle, so each presented result is taken in its cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Work item offered |
| in_ready | output | 1 | Work item accepted this cycle when high with in_valid |
| in_data | input | DW | Work item payload |
| eng_req_valid | output | NUM_ENG | Per-engine item offer |
| eng_req_ready | input | NUM_ENG | Per-engine item acceptance |
| eng_req_data | output | NUM_ENG*DW | Per-engine item payload, engine e at bits e*DW |
| eng_req_tag | output | NUM_ENG*TAGW | Per-engine sequence tag, engine e at bits e*TAGW |
| eng_rsp_valid | input | NUM_ENG | Per-engine result offer |
| eng_rsp_ready | output | NUM_ENG | Per-engine result acceptance |
| eng_rsp_data | input | NUM_ENG*DW | Per-engine result payload |
| eng_rsp_tag | input | NUM_ENG*TAGW | Tag returned with each result |
| out_valid | output | 1 | Ordered result offered |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | DW | Ordered result payload |
| out_tag | output | TAGW | Tag of the offered result |
| dup_err | output | 1 | Result hit an occupied slot or a same-cycle tag clash |

## Verification
The engines are modelled as random pools that return results in a randomly picked order and after random delays. This exposes any reliance on return order in the reassembly. A phase of random engine back-pressure with slow returns builds uneven loads, so a least-loaded choice can be told apart from round-robin and from a fixed priority; the all-idle start checks the tie rule. A phase with the output blocked fills the block to its cap, which separates a correct stall at DEPTH from tag reuse, and it also exercises output holding. A directed double return into an occupied slot checks the error flag and that the stored result survives.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // next sequence tag, wrapping at a power-of-two modulus
  function automatic logic [31:0] tag_next(logic [31:0] cur, int unsigned modulus);
    return (cur + 32'd1) & (modulus - 32'd1);
  endfunction

  // per-engine load update; a return at zero load leaves it at zero
  function automatic logic [31:0] load_step(logic [31:0] cur, logic add, logic sub);
    logic [31:0] n;
    n = cur;
    if (add) n = n + 32'd1;
    if (sub && (cur != 32'd0)) n = n - 32'd1;
    return n;
  endfunction

  // count of items held between dispatch and output release
  function automatic logic [31:0] occ_step(logic [31:0] cur, logic add, logic sub);
    return cur + {31'd0, add} - {31'd0, sub};
  endfunction

endpackage

// File: rtl/sdr_pick.sv
module sdr_pick #(
  parameter int NUM_ENG = 4,
  parameter int CW = 5,
  localparam int SELW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic [NUM_ENG*CW-1:0] loads,
  output logic [SELW-1:0]       sel
);

  logic [CW-1:0] best;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    sel  = '0;
    best = loads[CW-1:0];
    for (int e = 1; e < NUM_ENG; e++) begin
      if (loads[e*CW +: CW] < best) begin
        best = loads[e*CW +: CW];
        sel  = SELW'(e);
      end
    end
  end

endmodule

// File: rtl/sdr_dispatch.sv
module sdr_dispatch #(
  parameter int NUM_ENG = 4,
  parameter int DEPTH = 16,
  parameter int DW = 16,
  localparam int TAGW = $clog2(DEPTH),
  localparam int CW = TAGW + 1,
  localparam int SELW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DW-1:0]           in_data,
  output logic [NUM_ENG-1:0]      eng_req_valid,
  input  logic [NUM_ENG-1:0]      eng_req_ready,
  output logic [NUM_ENG*DW-1:0]   eng_req_data,
  output logic [NUM_ENG*TAGW-1:0] eng_req_tag,
  input  logic [NUM_ENG-1:0]      rsp_fire,
  input  logic                    out_fire,
  output logic                    disp_fire,
  output logic [TAGW-1:0]         disp_tag
);

  logic [NUM_ENG*CW-1:0] loads;
  logic [SELW-1:0]       sel;
  logic [CW-1:0]         inflight;
  logic [TAGW-1:0]       tag_q;
  logic                  room;

  sdr_pick #(.NUM_ENG(NUM_ENG), .CW(CW)) u_pick (
    .loads (loads),
    .sel   (sel)
  );

  assign room      = (inflight != CW'(DEPTH));
  assign in_ready  = room && eng_req_ready[sel];
  assign disp_fire = in_valid && in_ready;
  assign disp_tag  = tag_q;

  generate
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      logic [CW-1:0] cnt;
      logic          take;

      assign eng_req_valid[e]             = in_valid && room && (sel == SELW'(e));
      assign eng_req_data[e*DW +: DW]     = in_data;
      assign eng_req_tag[e*TAGW +: TAGW]  = tag_q;
      assign take                         = eng_req_valid[e] && eng_req_ready[e];
      assign loads[e*CW +: CW]            = cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= CW'(sdr_pkg::load_step(32'(cnt), take, rsp_fire[e]));
      end

      // the engine that received the item had no larger load than this one
      assert_least_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> (loads[sel*CW +: CW] <= cnt));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      tag_q    <= '0;
    end else begin
      inflight <= CW'(sdr_pkg::occ_step(32'(inflight), disp_fire, out_fire));
      if (disp_fire) tag_q <= TAGW'(sdr_pkg::tag_next(32'(tag_q), DEPTH));
    end
  end

  assert_inflight_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(DEPTH));

  assert_single_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_req_valid));

  assert_tag_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (tag_q == TAGW'($past(tag_q) + 1'b1)));

endmodule

// File: rtl/sdr_reorder.sv
module sdr_reorder #(
  parameter int NUM_ENG = 4,
  parameter int DEPTH = 16,
  parameter int DW = 16,
  localparam int TAGW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_ENG-1:0]      rsp_valid,
  input  logic [NUM_ENG*DW-1:0]   rsp_data,
  input  logic [NUM_ENG*TAGW-1:0] rsp_tag,
  input  logic                    disp_fire,
  input  logic [TAGW-1:0]         disp_tag,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic [TAGW-1:0]         out_tag,
  output logic                    out_fire,
  output logic                    dup_err
);

  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][DW-1:0] mem;
  logic [TAGW-1:0]          head;
  logic [DEPTH-1:0]         set_slot;
  logic [DEPTH-1:0]         clash_slot;
  logic [DEPTH-1:0][DW-1:0] wdata;

  // per slot: count matching returns; the lowest engine index supplies data
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      int hits;
      hits          = 0;
      wdata[s]      = '0;
      for (int e = NUM_ENG - 1; e >= 0; e--) begin
        if (rsp_valid[e] && (rsp_tag[e*TAGW +: TAGW] == TAGW'(s))) begin
          hits     = hits + 1;
          wdata[s] = rsp_data[e*DW +: DW];
        end
      end
      set_slot[s]   = (hits != 0) && !vld[s];
      clash_slot[s] = (hits > 1) || ((hits != 0) && vld[s]);
    end
  end

  assign dup_err   = |clash_slot;
  assign out_valid = vld[head];
  assign out_data  = mem[head];
  assign out_tag   = head;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      head <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (set_slot[s])                             vld[s] <= 1'b1;
        else if (out_fire && (head == TAGW'(s)))     vld[s] <= 1'b0;
      end
      if (out_fire) head <= TAGW'(sdr_pkg::tag_next(32'(head), DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (set_slot[s]) mem[s] <= wdata[s];
    end
  end

  // a newly issued tag never lands on a slot still holding a result
  assert_slot_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> !vld[disp_tag]);

  assert_hold_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  assert_head_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fire |=> $stable(head));

endmodule

// File: rtl/seq_dispatch_reorder.sv
module seq_dispatch_reorder #(
  parameter int NUM_ENG = 4,
  parameter int DEPTH = 16,
  parameter int DW = 16,
  localparam int TAGW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DW-1:0]           in_data,
  output logic [NUM_ENG-1:0]      eng_req_valid,
  input  logic [NUM_ENG-1:0]      eng_req_ready,
  output logic [NUM_ENG*DW-1:0]   eng_req_data,
  output logic [NUM_ENG*TAGW-1:0] eng_req_tag,
  input  logic [NUM_ENG-1:0]      eng_rsp_valid,
  output logic [NUM_ENG-1:0]      eng_rsp_ready,
  input  logic [NUM_ENG*DW-1:0]   eng_rsp_data,
  input  logic [NUM_ENG*TAGW-1:0] eng_rsp_tag,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic [TAGW-1:0]         out_tag,
  output logic                    dup_err
);

  logic [NUM_ENG-1:0] rsp_fire;
  logic               out_fire;
  logic               disp_fire;
  logic [TAGW-1:0]    disp_tag;

  // every slot is reserved at dispatch, so returns never need to wait
  assign eng_rsp_ready = {NUM_ENG{1'b1}};
  assign rsp_fire      = eng_rsp_valid & eng_rsp_ready;

  sdr_dispatch #(.NUM_ENG(NUM_ENG), .DEPTH(DEPTH), .DW(DW)) u_disp (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .eng_req_valid (eng_req_valid),
    .eng_req_ready (eng_req_ready),
    .eng_req_data  (eng_req_data),
    .eng_req_tag   (eng_req_tag),
    .rsp_fire      (rsp_fire),
    .out_fire      (out_fire),
    .disp_fire     (disp_fire),
    .disp_tag      (disp_tag)
  );

  sdr_reorder #(.NUM_ENG(NUM_ENG), .DEPTH(DEPTH), .DW(DW)) u_rob (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_fire),
    .rsp_data  (eng_rsp_data),
    .rsp_tag   (eng_rsp_tag),
    .disp_fire (disp_fire),
    .disp_tag  (disp_tag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .out_fire  (out_fire),
    .dup_err   (dup_err)
  );

  assert_rsp_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rsp_valid & ~eng_rsp_ready) == '0);

endmodule

// File: tb/sim_seq_dispatch_reorder.sv
module sim_seq_dispatch_reorder;
  localparam int N = 4;
  localparam int D = 16;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam logic [DW-1:0] KEY = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic [N-1:0] eng_req_valid;
  logic [N-1:0] eng_req_ready = '0;
  logic [N*DW-1:0] eng_req_data;
  logic [N*TW-1:0] eng_req_tag;
  logic [N-1:0] eng_rsp_valid = '0;
  logic [N-1:0] eng_rsp_ready;
  logic [N*DW-1:0] eng_rsp_data = '0;
  logic [N*TW-1:0] eng_rsp_tag = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_tag;
  logic dup_err;

  always #2 clk = ~clk;

  seq_dispatch_reorder #(.NUM_ENG(N), .DEPTH(D), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_data(eng_req_data), .eng_req_tag(eng_req_tag),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_data(eng_rsp_data), .eng_rsp_tag(eng_rsp_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .dup_err(dup_err));

  int checks = 0;
  int errors = 0;
  int ld [N];
  int pool_n [N];
  int pool_tag [N][D];
  logic [DW-1:0] pool_dat [N][D];
  int cur_idx [N];
  logic [DW-1:0] exp_q [$];
  int inflight = 0;
  int next_tag = 0;
  int out_cnt = 0;
  bit hold_pend = 0;
  logic [DW-1:0] hold_dat;
  logic [TW-1:0] hold_tag;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // smallest load first, then first engine holding it
  function automatic int pick_engine();
    int m = ld[0];
    for (int e = 1; e < N; e++) if (ld[e] < m) m = ld[e];
    for (int e = 0; e < N; e++) if (ld[e] == m) return e;
    return 0;
  endfunction

  function automatic logic [DW-1:0] engine_fn(logic [DW-1:0] d);
    return d ^ KEY;
  endfunction

  task automatic step(input bit inj_dup);
    int sel;
    bit room;
    bit fire;
    @(negedge clk);
    sel  = pick_engine();
    room = (inflight < D);
    check(dup_err == inj_dup, "R8 dup_err", 32'(dup_err), 32'(inj_dup));
    check(eng_rsp_ready == {N{1'b1}}, "R9 rsp_ready", 32'(eng_rsp_ready), 32'hF);
    check(in_ready == (room && eng_req_ready[sel]), room ? "R4 in_ready" : "R5 stall",
          32'(in_ready), 32'(room && eng_req_ready[sel]));
    if (in_valid)
      check(eng_req_valid == (room ? N'(1 << sel) : '0), "R3 engine choice",
            32'(eng_req_valid), room ? 32'(1 << sel) : 0);
    else
      check(eng_req_valid == '0, "R4 idle offer", 32'(eng_req_valid), 0);
    fire = in_valid && in_ready;
    if (fire) begin
      check(eng_req_tag[sel*TW +: TW] == TW'(next_tag), "R2 tag",
            32'(eng_req_tag[sel*TW +: TW]), 32'(next_tag));
      check(eng_req_data[sel*DW +: DW] == in_data, "R4 data",
            32'(eng_req_data[sel*DW +: DW]), 32'(in_data));
    end
    if (hold_pend)
      check(out_valid && out_data == hold_dat && out_tag == hold_tag, "R7 hold",
            {out_valid, 7'd0, out_tag, 4'd0, out_data}, {1'b1, 7'd0, hold_tag, 4'd0, hold_dat});
    hold_pend = out_valid && !out_ready;
    hold_dat  = out_data;
    hold_tag  = out_tag;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R6 extra output", 32'(out_data), 0);
      else begin
        check(out_data == exp_q[0], "R6 order data", 32'(out_data), 32'(exp_q[0]));
        check(out_tag == TW'(out_cnt), "R6 out_tag", 32'(out_tag), 32'(out_cnt % D));
        void'(exp_q.pop_front());
      end
      out_cnt++;
      inflight--;
    end
    for (int e = 0; e < N; e++) begin
      if (eng_rsp_valid[e] && !(inj_dup && e == 1)) begin
        pool_tag[e][cur_idx[e]] = pool_tag[e][pool_n[e]-1];
        pool_dat[e][cur_idx[e]] = pool_dat[e][pool_n[e]-1];
        pool_n[e]--;
        if (ld[e] > 0) ld[e]--;
      end
    end
    if (fire) begin
      pool_tag[sel][pool_n[sel]] = next_tag;
      pool_dat[sel][pool_n[sel]] = in_data;
      pool_n[sel]++;
      ld[sel]++;
      exp_q.push_back(engine_fn(in_data));
      next_tag = (next_tag + 1) % D;
      inflight++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input int p_in, input int p_rsp, input int p_out, input int p_rdy);
    in_valid  = ($urandom % 100) < p_in;
    in_data   = DW'($urandom);
    out_ready = ($urandom % 100) < p_out;
    for (int e = 0; e < N; e++) begin
      eng_req_ready[e] = ($urandom % 100) < p_rdy;
      eng_rsp_valid[e] = 1'b0;
      if (pool_n[e] > 0 && ($urandom % 100) < p_rsp) begin
        cur_idx[e] = int'($urandom % pool_n[e]);
        eng_rsp_valid[e] = 1'b1;
        eng_rsp_tag[e*TW +: TW] = TW'(pool_tag[e][cur_idx[e]]);
        eng_rsp_data[e*DW +: DW] = engine_fn(pool_dat[e][cur_idx[e]]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    for (int e = 0; e < N; e++) begin ld[e] = 0; pool_n[e] = 0; cur_idx[e] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(dup_err == 1'b0, "R1 dup_err", 32'(dup_err), 0);
    @(posedge clk); #1;
    // R1/R3 tie at start: all idle, item goes to engine 0 with tag 0
    in_valid = 1'b1; in_data = 16'h00A1; eng_req_ready = '1; out_ready = 1'b1;
    #0;
    step(0);
    check(next_tag == 1 && ld[0] == 1, "R1 first tag at engine 0", 32'(ld[0]), 1);
    for (int i = 0; i < 3000; i++) begin drive(70, 40, 70, 80); step(0); end
    // fill to the cap with output blocked
    for (int i = 0; i < 60; i++) begin drive(100, 50, 0, 100); step(0); end
    check(inflight == D, "R5 filled to cap", 32'(inflight), D);
    for (int i = 0; i < 100; i++) begin drive(0, 100, 100, 100); step(0); end
    // slow returns, uneven loads
    for (int i = 0; i < 2000; i++) begin drive(80, 10, 60, 60); step(0); end
    t = 0;
    while ((exp_q.size() != 0 || inflight != 0) && t < 1000) begin
      drive(0, 100, 100, 100); step(0); t++;
    end
    check(exp_q.size() == 0, "R6 drained", 32'(exp_q.size()), 0);
    // R8: duplicate return into an occupied slot
    in_valid = 1'b1; in_data = 16'h1234; out_ready = 1'b0; eng_req_ready = '1; eng_rsp_valid = '0;
    step(0);
    t = pick_engine();
    for (int e = 0; e < N; e++) if (pool_n[e] > 0) t = e;
    in_valid = 1'b0;
    cur_idx[t] = 0;
    eng_rsp_valid = '0; eng_rsp_valid[t] = 1'b1;
    eng_rsp_tag[t*TW +: TW] = TW'(pool_tag[t][0]);
    eng_rsp_data[t*DW +: DW] = engine_fn(pool_dat[t][0]);
    step(0);
    eng_rsp_valid = '0; eng_rsp_valid[1] = 1'b1;
    eng_rsp_tag[1*TW +: TW] = out_tag;
    eng_rsp_data[1*DW +: DW] = 16'hFFFF;
    step(1);
    eng_rsp_valid = '0; out_ready = 1'b1;
    step(0);
    check(out_cnt > 0 && exp_q.size() == 0, "R8 stored result kept", 32'(exp_q.size()), 0);
    for (int i = 0; i < 4; i++) begin drive(0, 100, 100, 100); step(0); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule